// File: doc/BRIEF.md
# Byte Shuffle Unit

This block builds a 64-bit result by choosing any eight bytes from the sixteen bytes of two 64-bit sources. The upper 32 bits of a 64-bit graphics status word hold eight 4-bit selectors, one for each result byte. Each selector names one byte of a sixteen-byte pool. The pool is numbered big-endian: the first source supplies indices 0 to 7 and the second supplies indices 8 to 15. Software uses it to permute, reverse, broadcast or interleave packed pixel data.

Operands enter on a valid/ready input channel as one beat (status word plus both sources). The shuffled word leaves on a valid/ready output channel from a single register stage. The input is accepted whenever the output register is empty or is being drained in the same cycle. A stalled output holds its data until it is taken, and full throughput is one beat per cycle.

Top module: `byte_shuffle_unit`

## Requirements
- R1: Result byte i, counted from the most significant byte (i = 0..7), is selected by status bits [63-4i : 60-4i]; byte i occupies out_data[63-8i : 56-8i].
- R2: Pool index k in 0..7 is byte k of in_src_a counted from its most significant byte (bits [63-8k : 56-8k]); index k in 8..15 is byte k-8 of in_src_b counted the same way. Selector 0x01234567 therefore returns in_src_a, and 0x89abcdef returns in_src_b.
- R3: Status bits 31:0 have no effect on the result.
- R4: Selectors may repeat, so several result bytes may copy the same pool byte; a selector word with all nibbles equal broadcasts one byte to all eight positions.
- R5: A beat accepted at a clock edge (in_valid and in_ready both high) appears on out_data with out_valid high right after that edge.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R7: in_ready is high exactly when out_valid is low or out_ready is high.
- R8: During and directly after reset, out_valid is low and in_ready is high.
- R9: With out_ready held high, a new beat is accepted on every clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Block can take an input beat |
| in_status | input | 64 | Graphics status word; bits 63:32 carry the eight selectors |
| in_src_a | input | 64 | First source, pool indices 0 to 7 |
| in_src_b | input | 64 | Second source, pool indices 8 to 15 |
| out_valid | output | 1 | Result beat is present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_data | output | 64 | Shuffled result |

## Verification
The bound checker checks the handshake rules on every cycle: the ready equation, one-cycle latency after acceptance, and holding data under a stall. It also checks that every accepted beat comes out as the byte selected by each nibble, which it computes by shifting the pool. The bench scenarios are needed to show that the low half of the status word is ignored. They also cover the fixed selector patterns, that is identity for either source, full reversal and broadcast, along with the reset state and one-beat-per-cycle throughput under steady readiness.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  localparam int unsigned DEF_LANE_W   = 8;
  localparam int unsigned DEF_LANES    = 8;
  localparam int unsigned DEF_MASK_LSB = 32;
  localparam int unsigned DEF_CTRL_W   = 64;

  // Byte at big-endian pool position k of a flat pool holding npool lanes.
  function automatic int unsigned pool_lsb(int unsigned k, int unsigned npool,
                                           int unsigned lane_w);
    return (npool - 1 - k) * lane_w;
  endfunction
endpackage

// File: rtl/shuf_lane_mux.sv
module shuf_lane_mux
  import shuf_pkg::*;
#(
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter int unsigned POOL   = 2 * DEF_LANES,
  parameter int unsigned SEL_W  = $clog2(POOL)
) (
  input  logic [POOL*LANE_W-1:0] pool,
  input  logic [SEL_W-1:0]       sel,
  output logic [LANE_W-1:0]      lane
);
  always_comb begin
    lane = '0;
    for (int k = 0; k < POOL; k++) begin
      if (sel == SEL_W'(k)) begin
        lane = pool[pool_lsb(k, POOL, LANE_W) +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/shuf_xbar.sv
module shuf_xbar
  import shuf_pkg::*;
#(
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter int unsigned LANES  = DEF_LANES,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned POOL   = 2 * LANES,
  localparam int unsigned SEL_W  = $clog2(POOL)
) (
  input  logic [LANES*SEL_W-1:0] selectors,
  input  logic [WORD_W-1:0]      src_a,
  input  logic [WORD_W-1:0]      src_b,
  output logic [WORD_W-1:0]      result
);
  logic [2*WORD_W-1:0] pool;
  assign pool = {src_a, src_b};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // Lane i counts from the most significant end of both words.
    localparam int unsigned SEL_LSB = (LANES - 1 - i) * SEL_W;
    localparam int unsigned OUT_LSB = (LANES - 1 - i) * LANE_W;
    shuf_lane_mux #(
      .LANE_W(LANE_W),
      .POOL  (POOL),
      .SEL_W (SEL_W)
    ) u_mux (
      .pool(pool),
      .sel (selectors[SEL_LSB +: SEL_W]),
      .lane(result[OUT_LSB +: LANE_W])
    );
  end
endmodule

// File: rtl/shuf_out_stage.sv
module shuf_out_stage #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [WIDTH-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [WIDTH-1:0] dn_data
);
  logic             vld_q;
  logic [WIDTH-1:0] data_q;

  assign up_ready = !vld_q || dn_ready;
  assign dn_valid = vld_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      vld_q <= up_valid;
      if (up_valid) begin
        data_q <= up_data;
      end
    end
  end
endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
  import shuf_pkg::*;
#(
  parameter int unsigned LANE_W   = DEF_LANE_W,
  parameter int unsigned LANES    = DEF_LANES,
  parameter int unsigned CTRL_W   = DEF_CTRL_W,
  parameter int unsigned MASK_LSB = DEF_MASK_LSB,
  localparam int unsigned WORD_W  = LANE_W * LANES,
  localparam int unsigned SEL_W   = $clog2(2 * LANES),
  localparam int unsigned MASK_W  = LANES * SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CTRL_W-1:0] in_status,
  input  logic [WORD_W-1:0] in_src_a,
  input  logic [WORD_W-1:0] in_src_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  logic [MASK_W-1:0] selectors;
  logic [WORD_W-1:0] shuffled;
  logic              unused_status_low;

  assign selectors         = in_status[MASK_LSB +: MASK_W];
  assign unused_status_low = ^in_status[MASK_LSB-1:0];

  shuf_xbar #(
    .LANE_W(LANE_W),
    .LANES (LANES)
  ) u_xbar (
    .selectors(selectors),
    .src_a    (in_src_a),
    .src_b    (in_src_b),
    .result   (shuffled)
  );

  shuf_out_stage #(
    .WIDTH(WORD_W)
  ) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data (shuffled),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (out_data)
  );
endmodule

// File: rtl/byte_shuffle_unit_chk.sv
module byte_shuffle_unit_chk #(
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned LANES    = 8,
  parameter int unsigned CTRL_W   = 64,
  parameter int unsigned MASK_LSB = 32,
  localparam int unsigned WORD_W  = LANE_W * LANES,
  localparam int unsigned SEL_W   = $clog2(2 * LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CTRL_W-1:0] in_status,
  input logic [WORD_W-1:0] in_src_a,
  input logic [WORD_W-1:0] in_src_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data
);
  // Model by shifting the pool left so the chosen byte lands on top.
  function automatic logic [WORD_W-1:0] model(logic [CTRL_W-1:0] st,
                                               logic [WORD_W-1:0] a,
                                               logic [WORD_W-1:0] b);
    logic [2*WORD_W-1:0] sh;
    logic [WORD_W-1:0]   r;
    r = '0;
    for (int i = 0; i < LANES; i++) begin
      sh = {a, b} << (LANE_W * int'(st[MASK_LSB + (LANES-1-i)*SEL_W +: SEL_W]));
      r  = (r << LANE_W) | WORD_W'(sh[2*WORD_W-1 -: LANE_W]);
    end
    return r;
  endfunction

  // R7
  a_r7_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  // R5
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R1, R2
  a_r1_r2_selected_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (out_data == model($past(in_status), $past(in_src_a), $past(in_src_b))));
endmodule

bind byte_shuffle_unit byte_shuffle_unit_chk #(
  .LANE_W  (LANE_W),
  .LANES   (LANES),
  .CTRL_W  (CTRL_W),
  .MASK_LSB(MASK_LSB)
) u_chk (.*);

// File: tb/byte_shuffle_unit_bench.sv
module byte_shuffle_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_status = '0;
  logic [63:0] in_src_a = '0;
  logic [63:0] in_src_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int acc_cyc = 0;
  bit bp_on   = 1'b0;
  bit done    = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  byte_shuffle_unit u_byte_shuffle_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_status(in_status), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [63:0] ref_shuffle(logic [63:0] st, logic [63:0] a,
                                               logic [63:0] b);
    logic [7:0] pool [16];
    logic [63:0] r;
    for (int k = 0; k < 8; k++) begin
      pool[k]   = a[63-8*k -: 8];
      pool[k+8] = b[63-8*k -: 8];
    end
    for (int i = 0; i < 8; i++) r[63-8*i -: 8] = pool[st[63-4*i -: 4]];
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the falling edge
  // that follows the accepting rising edge, with in_valid still high.
  task automatic send(string tag, logic [63:0] st, logic [63:0] a, logic [63:0] b);
    in_status = st; in_src_a = a; in_src_b = b; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    exp_q.push_back(ref_shuffle(st, a, b));
    tag_q.push_back(tag);
    @(negedge clk);
    acc_cyc = cyc;
  endtask

  task automatic idle();
    in_valid = 1'b0;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Back-pressure generator.
  always @(negedge clk) out_ready <= bp_on ? 1'($urandom_range(0, 1)) : 1'b1;

  // Monitor / scoreboard.
  initial begin
    logic        stalled = 1'b0;
    logic [63:0] held = '0;
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        check("R7", {63'd0, in_ready}, {63'd0, (!out_valid || out_ready)});
        if (stalled) check("R6", {out_valid, out_data[62:0]}, {1'b1, held[62:0]});
        if (stalled) check("R6", out_data, held);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check("R5 unexpected beat", out_data, 64'hx);
          end else begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, out_data, e);
          end
        end
        stalled = out_valid && !out_ready;
        held    = out_data;
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Watchdog.
  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [63:0] a0, b0;
    a0 = 64'h0011_2233_4455_6677;
    b0 = 64'h8899_aabb_ccdd_eeff;

    // R8: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R8", {62'd0, out_valid, in_ready}, {62'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R8", {62'd0, out_valid, in_ready}, {62'd0, 1'b0, 1'b1});
    @(negedge clk);

    // R5: result visible the cycle after acceptance
    send("R5", {32'h0123_4567, 32'h0}, a0, b0);
    idle(); #1;
    check("R5", {63'd0, out_valid}, 64'd1);
    check("R5", out_data, a0);
    drain();

    // R2: identity selectors
    send("R2 src_a", {32'h0123_4567, 32'h0}, a0, b0);
    send("R2 src_b", {32'h89ab_cdef, 32'h0}, a0, b0);
    // R1: full reversal of each source and interleave
    send("R1 reverse", {32'hfedc_ba98, 32'h0}, a0, b0);
    send("R1 reverse a", {32'h7654_3210, 32'h0}, a0, b0);
    send("R1 interleave", {32'h0819_2a3b, 32'h0}, a0, b0);
    // R4: broadcast and repeats
    send("R4 broadcast", {32'h3333_3333, 32'h0}, a0, b0);
    send("R4 repeat", {32'hff00_ff00, 32'h0}, a0, b0);
    // R3: low half ignored
    send("R3", {32'h0123_4567, 32'hdead_beef}, a0, b0);
    send("R3", {32'hfedc_ba98, 32'hffff_ffff}, a0, b0);
    drain();

    // R9: back-to-back acceptance with out_ready steady
    begin
      int first;
      send("R9", {32'h0123_4567, 32'h0}, a0, b0);
      first = acc_cyc;
      for (int k = 0; k < 5; k++) send("R9", {32'h89ab_cdef, 32'h0}, a0 + 64'(k), b0);
      check("R9", 64'(acc_cyc - first), 64'd5);
    end
    drain();

    // R1: random selectors under random back-pressure (covers R6, R7)
    bp_on = 1'b1;
    for (int k = 0; k < 300; k++) begin
      send("R1 random", {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
      if ((k % 7) == 0) begin
        idle();
        @(negedge clk);
      end
    end
    bp_on = 1'b0;
    drain();

    done = 1'b1;
    finish_run();
  end
endmodule